// File: doc/BRIEF.md
# Two-Channel Interval Timer with APB Register Access

This peripheral provides two independent down-counting timer channels behind a simple APB-style register interface. Each channel can run as one 32-bit timer, as two 16-bit timers or as four 8-bit timers. Every timer has its own enable, interrupt-enable and sticky expiry flag. When a timer's count has reached zero, the next tick reloads it and sets its flag. Periodic ticks therefore need no software action. For a single event, software disables the timer once the flag is seen.

A channel counts either every bus-clock cycle or the rising edges of an external tick input, which is synchronised inside the block. The count runs downward, so software reads elapsed time as the bitwise inverse of the counter. One level-sensitive interrupt line combines all enabled flags. Accesses complete in one access phase with no wait states. Writes take effect on the clock edge that ends the access phase, and read data comes combinationally from the address.

Top module: `apb_interval_timer`

## Requirements
- R1: Offset 0x00 returns the identification word (default 0x54490102) and offset 0x10 returns the configuration word 0x00000042 (4 timers per channel in bits 7:4, 2 channels in bits 3:0). Both are read-only, and any unmapped offset such as 0x0C reads as zero.
- R2: Flag registers are interrupt-enable at 0x14, status at 0x18 and channel-enable at 0x1C. Timer i of channel c uses bit 4*c+i. Channel c has control at 0x20+0x10*c, reload at 0x24+0x10*c and a read-only counter at 0x28+0x10*c.
- R3: After reset, every register and counter reads zero and irq is low.
- R4: On the first clock edge after the write that sets a timer's enable bit, its counter lane loads from its reload lane. A reload value written while the timer is disabled is therefore the one used at the next enable.
- R5: In 32-bit mode (control bits 2:0 = 1), each tick decrements the counter. A tick that finds the counter at zero reloads it and sets the status flag, so the period is reload+1 ticks. A reload of 0xFFFFFFFF is valid, and the inverted counter gives the elapsed ticks.
- R6: In 16-bit mode (control = 2), timers 0 and 1 use bits 15:0 and 31:16. In 8-bit mode (control = 3), timers 0 to 3 use bytes 0 to 3. Each lane counts, expires and reloads independently under its own enable bit.
- R7: Control bit 3 = 1 counts every bus-clock cycle. Control bit 3 = 0 counts rising edges of ext_tick after a two-flop synchroniser, and the counter does not move between edges.
- R8: While a timer's enable bit is clear, its counter lane holds its value.
- R9: Status bits are sticky. Writing 1 clears a bit and writing 0 leaves it unchanged. An expiry in the same cycle as a clear leaves the bit set.
- R10: irq is high exactly while some status bit and its matching interrupt-enable bit are both set. A flag whose enable is clear does not raise irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (8) | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| ext_tick | input | 1 | Asynchronous external tick |
| irq | output | 1 | Level interrupt request |

## Verification
An enabling write lands on edge E, and the counter holds the reload value R after edge E+1. With the bus clock it then reads R-w after E+1+w, which is exactly where a read issued w idle cycles after the write samples it. The flag and irq therefore rise after edge E+R+2, and the bench samples irq on the falling edges just before and just after that edge. An external tick held high for three cycles produces one decrement: two cycles pass through the synchroniser and one through the edge detector. The bench waits out that delay before it reads the counter, and every sample is taken on a falling edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW        = 32;
  localparam int LANES     = 4;
  localparam int OFF_ID    = 'h00;
  localparam int OFF_CFG   = 'h10;
  localparam int OFF_IEN   = 'h14;
  localparam int OFF_IST   = 'h18;
  localparam int OFF_CHEN  = 'h1C;
  localparam int OFF_CHB   = 'h20;
  localparam int CH_STRIDE = 'h10;
  localparam int OFF_CTL   = 'h0;
  localparam int OFF_REL   = 'h4;
  localparam int OFF_CNT   = 'h8;

  typedef enum logic [2:0] {
    MODE_OFF = 3'd0,
    MODE_W32 = 3'd1,
    MODE_W16 = 3'd2,
    MODE_W8  = 3'd3
  } mode_e;
endpackage

// File: rtl/tmr_tick_sync.sv
module tmr_tick_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_async,
  output logic tick_pulse
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= tick_async;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign tick_pulse = sync_q & ~last_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan import tmr_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ctrl,
  input  logic [DW-1:0]    reload,
  input  logic [LANES-1:0] en,
  input  logic             ext_pulse,
  output logic [DW-1:0]    cnt,
  output logic [LANES-1:0] expire
);
  logic [DW-1:0]    cnt_q, cnt_d;
  logic [LANES-1:0] en_d_q, exp_d;
  logic             tick;
  mode_e            mode;

  assign tick = ctrl[3] ? 1'b1 : ext_pulse;
  assign mode = mode_e'(ctrl[2:0]);

  always_comb begin
    cnt_d = cnt_q;
    exp_d = '0;
    unique case (mode)
      MODE_W32: begin
        if (en[0] && !en_d_q[0]) cnt_d = reload;
        else if (en[0] && tick) begin
          if (cnt_q == '0) begin
            cnt_d    = reload;
            exp_d[0] = 1'b1;
          end else cnt_d = cnt_q - 1'b1;
        end
      end
      MODE_W16: begin
        for (int t = 0; t < 2; t++) begin
          if (en[t] && !en_d_q[t]) cnt_d[t*16 +: 16] = reload[t*16 +: 16];
          else if (en[t] && tick) begin
            if (cnt_q[t*16 +: 16] == '0) begin
              cnt_d[t*16 +: 16] = reload[t*16 +: 16];
              exp_d[t]          = 1'b1;
            end else cnt_d[t*16 +: 16] = cnt_q[t*16 +: 16] - 1'b1;
          end
        end
      end
      MODE_W8: begin
        for (int t = 0; t < LANES; t++) begin
          if (en[t] && !en_d_q[t]) cnt_d[t*8 +: 8] = reload[t*8 +: 8];
          else if (en[t] && tick) begin
            if (cnt_q[t*8 +: 8] == '0) begin
              cnt_d[t*8 +: 8] = reload[t*8 +: 8];
              exp_d[t]        = 1'b1;
            end else cnt_d[t*8 +: 8] = cnt_q[t*8 +: 8] - 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      en_d_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      en_d_q <= en;
    end
  end

  assign cnt    = cnt_q;
  assign expire = exp_d;
endmodule

// File: rtl/apb_interval_timer.sv
module apb_interval_timer import tmr_pkg::*; #(
  parameter int          NUM_CH   = 2,
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] ID_VALUE = 32'h5449_0102
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  input  logic              ext_tick,
  output logic              irq
);
  localparam int          FW        = NUM_CH * LANES;
  localparam logic [31:0] CFG_VALUE = 32'((LANES << 4) | NUM_CH);

  logic [FW-1:0]                ien_q, ist_q, chen_q, ist_d, expire_all;
  logic [NUM_CH-1:0][3:0]       ctrl_q;
  logic [NUM_CH-1:0][DW-1:0]    rel_q, ch_cnt;
  logic [NUM_CH-1:0]            ctl_we, rel_we;
  logic                         wr, ien_we, ist_we, chen_we, ext_pulse;

  assign wr      = psel & penable & pwrite;
  assign ien_we  = wr && (paddr == ADDR_W'(OFF_IEN));
  assign ist_we  = wr && (paddr == ADDR_W'(OFF_IST));
  assign chen_we = wr && (paddr == ADDR_W'(OFF_CHEN));

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      ctl_we[c] = wr && (paddr == ADDR_W'(OFF_CHB + c*CH_STRIDE + OFF_CTL));
      rel_we[c] = wr && (paddr == ADDR_W'(OFF_CHB + c*CH_STRIDE + OFF_REL));
    end
  end

  // expiry in the same cycle as a clear keeps the flag
  assign ist_d = (ist_q & ~(ist_we ? pwdata[FW-1:0] : '0)) | expire_all;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ien_q  <= '0;
      ist_q  <= '0;
      chen_q <= '0;
      ctrl_q <= '0;
      rel_q  <= '0;
    end else begin
      ist_q <= ist_d;
      if (ien_we)  ien_q  <= pwdata[FW-1:0];
      if (chen_we) chen_q <= pwdata[FW-1:0];
      for (int c = 0; c < NUM_CH; c++) begin
        if (ctl_we[c]) ctrl_q[c] <= pwdata[3:0];
        if (rel_we[c]) rel_q[c]  <= pwdata;
      end
    end
  end

  tmr_tick_sync u_sync (
    .clk        (pclk),
    .rst_n      (presetn),
    .tick_async (ext_tick),
    .tick_pulse (ext_pulse)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_chan u_chan (
      .clk       (pclk),
      .rst_n     (presetn),
      .ctrl      (ctrl_q[c]),
      .reload    (rel_q[c]),
      .en        (chen_q[c*LANES +: LANES]),
      .ext_pulse (ext_pulse),
      .cnt       (ch_cnt[c]),
      .expire    (expire_all[c*LANES +: LANES])
    );
  end

  always_comb begin
    prdata = '0;
    if (paddr == ADDR_W'(OFF_ID))   prdata = ID_VALUE;
    if (paddr == ADDR_W'(OFF_CFG))  prdata = CFG_VALUE;
    if (paddr == ADDR_W'(OFF_IEN))  prdata = DW'(ien_q);
    if (paddr == ADDR_W'(OFF_IST))  prdata = DW'(ist_q);
    if (paddr == ADDR_W'(OFF_CHEN)) prdata = DW'(chen_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (paddr == ADDR_W'(OFF_CHB + c*CH_STRIDE + OFF_CTL)) prdata = DW'(ctrl_q[c]);
      if (paddr == ADDR_W'(OFF_CHB + c*CH_STRIDE + OFF_REL)) prdata = rel_q[c];
      if (paddr == ADDR_W'(OFF_CHB + c*CH_STRIDE + OFF_CNT)) prdata = ch_cnt[c];
    end
  end

  assign irq = |(ist_q & ien_q);
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int FW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_ist,
  input logic [FW-1:0] ist,
  input logic [FW-1:0] ien,
  input logic          irq,
  input logic [3:0]    en0,
  input logic [2:0]    mode0,
  input logic [31:0]   reload0,
  input logic [31:0]   cnt0
);
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_ist) |-> ((ist & $past(ist)) == $past(ist)));                // R9

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (en0 == 4'b0) |=> $stable(cnt0));                                      // R8

  AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en0[0]) && mode0 == 3'd1) |=> (cnt0 == $past(reload0)));        // R4

  AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ist[0]) |-> ($past(cnt0[7:0]) == 8'd0));                         // R5

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ist != '0));                                                  // R10

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);                                                 // R10
endmodule

bind apb_interval_timer tmr_checker u_chk (
  .clk     (pclk),
  .rst_n   (presetn),
  .wr_ist  (ist_we),
  .ist     (ist_q),
  .ien     (ien_q),
  .irq     (irq),
  .en0     (chen_q[3:0]),
  .mode0   (ctrl_q[0][2:0]),
  .reload0 (rel_q[0]),
  .cnt0    (ch_cnt[0])
);

// File: tb/apb_interval_timer_bench.sv
`timescale 1ns/1ps
module apb_interval_timer_bench;
  logic        pclk, presetn, psel, penable, pwrite, ext_tick, irq;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  int checks, failures;
  bit done;

  apb_interval_timer u_apb_interval_timer (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .ext_tick(ext_tick), .irq(irq)
  );

  initial pclk = 1'b0;
  always #4 pclk = ~pclk;

  typedef struct packed {
    logic [7:0]  ch;
    logic [3:0]  ctrl;
    logic [31:0] rel;
    logic [3:0]  en;
    logic [7:0]  wait_n;
    logic [31:0] exp;
  } vec_t;

  // timer counts R-w after w idle cycles, modulo R+1 per lane
  localparam vec_t VECS [5] = '{
    '{8'd0, 4'h9, 32'd100,       4'h1, 8'd10, 32'd90},         // R5
    '{8'd1, 4'h9, 32'h0000_1000, 4'h1, 8'd0,  32'h0000_1000},  // R2 R4
    '{8'd0, 4'hA, 32'h0030_0005, 4'h3, 8'd7,  32'h0029_0004},  // R6
    '{8'd1, 4'hB, 32'h0403_0201, 4'hF, 8'd5,  32'h0402_0000},  // R6
    '{8'd0, 4'h9, 32'hFFFF_FFFF, 4'h1, 8'd5,  32'hFFFF_FFFA}   // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk); penable = 1'b1;
    @(negedge pclk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk); penable = 1'b1; #1 d = prdata;
    @(negedge pclk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pulse_ext();
    ext_tick = 1'b1; repeat (3) @(negedge pclk);
    ext_tick = 1'b0; repeat (3) @(negedge pclk);
  endtask

  initial begin
    repeat (200000) @(posedge pclk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    checks = 0; failures = 0; done = 1'b0;
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; ext_tick = 0;
    presetn = 1'b0;
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);

    // R3 reset state
    check("R3 irq", {31'b0, irq}, 32'h0);
    apb_rd(8'h1C, d); check("R3 chen", d, 32'h0);
    apb_rd(8'h18, d); check("R3 status", d, 32'h0);
    apb_rd(8'h28, d); check("R3 counter", d, 32'h0);
    apb_rd(8'h34, d); check("R3 reload ch1", d, 32'h0);
    // R1 identification, configuration, unmapped
    apb_rd(8'h00, d); check("R1 id", d, 32'h5449_0102);
    apb_rd(8'h10, d); check("R1 cfg", d, 32'h0000_0042);
    apb_rd(8'h0C, d); check("R1 unmapped", d, 32'h0);
    apb_wr(8'h00, 32'h1234_5678);
    apb_rd(8'h00, d); check("R1 id read-only", d, 32'h5449_0102);

    // vector table
    for (int i = 0; i < 5; i++) begin
      apb_wr(8'h20 + VECS[i].ch * 8'h10, {28'b0, VECS[i].ctrl});
      apb_wr(8'h24 + VECS[i].ch * 8'h10, VECS[i].rel);
      apb_wr(8'h1C, 32'(VECS[i].en) << (4 * VECS[i].ch));
      repeat (int'(VECS[i].wait_n)) @(negedge pclk);
      apb_rd(8'h28 + VECS[i].ch * 8'h10, d);
      check($sformatf("R5 R6 vector %0d counter", i), d, VECS[i].exp);
      apb_wr(8'h1C, 32'h0);
      apb_wr(8'h18, 32'hFF);
    end
    // R5 elapsed ticks from inverted counter of last vector
    check("R5 elapsed", ~d, 32'd5);

    // R8 hold while disabled, R4 new reload used at enable
    apb_rd(8'h28, d);
    repeat (10) @(negedge pclk);
    apb_rd(8'h28, d2); check("R8 hold", d2, d);
    apb_wr(8'h24, 32'd50);
    apb_rd(8'h28, d2); check("R8 reload write no effect", d2, d);
    apb_wr(8'h1C, 32'h1);
    apb_rd(8'h28, d); check("R4 load at enable", d, 32'd50);
    apb_wr(8'h1C, 32'h0);

    // R10 and R5 expiry timing with reload 3
    apb_wr(8'h14, 32'h1);
    apb_wr(8'h24, 32'd3);
    apb_wr(8'h18, 32'hFF);
    apb_wr(8'h1C, 32'h1);
    repeat (4) @(negedge pclk);
    check("R5 irq before expiry", {31'b0, irq}, 32'h0);
    @(negedge pclk);
    check("R10 irq at expiry", {31'b0, irq}, 32'h1);
    apb_wr(8'h1C, 32'h0);
    apb_rd(8'h18, d); check("R9 sticky", d, 32'h1);
    apb_wr(8'h18, 32'h0);
    apb_rd(8'h18, d); check("R9 write zero no effect", d, 32'h1);
    check("R10 irq held", {31'b0, irq}, 32'h1);
    apb_wr(8'h18, 32'h1);
    apb_rd(8'h18, d); check("R9 w1c", d, 32'h0);
    check("R10 irq cleared", {31'b0, irq}, 32'h0);

    // R10 masked flag
    apb_wr(8'h14, 32'h0);
    apb_wr(8'h24, 32'd1);
    apb_wr(8'h1C, 32'h1);
    repeat (10) @(negedge pclk);
    apb_rd(8'h18, d); check("R10 flag set while masked", d, 32'h1);
    check("R10 irq masked", {31'b0, irq}, 32'h0);
    apb_wr(8'h1C, 32'h0);
    apb_wr(8'h18, 32'hFF);

    // R7 external tick
    apb_wr(8'h14, 32'h1);
    apb_wr(8'h20, 32'h1);
    apb_wr(8'h24, 32'd2);
    apb_wr(8'h1C, 32'h1);
    repeat (20) @(negedge pclk);
    apb_rd(8'h28, d); check("R7 no count without ext edge", d, 32'd2);
    pulse_ext();
    apb_rd(8'h28, d); check("R7 one ext edge", d, 32'd1);
    pulse_ext();
    apb_rd(8'h28, d); check("R7 two ext edges", d, 32'd0);
    check("R7 no irq before third edge", {31'b0, irq}, 32'h0);
    pulse_ext();
    check("R7 irq after third edge", {31'b0, irq}, 32'h1);
    apb_rd(8'h28, d); check("R7 reloaded", d, 32'd2);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule